// File: doc/BRIEF.md
# Memory Refresh Register Counter

This block holds the 8-bit refresh register of a small 8-bit processor core. The low seven bits act as a counter that advances by one each time the core performs a qualifying step. The most significant bit is never touched by counting, so software can park a flag there and have it survive any number of increments.

Four kinds of step advance the counter:
- an ordinary opcode fetch,
- every clock cycle the core spends halted,
- the leading byte of a prefixed instruction,
- acceptance of either interrupt kind, maskable or non-maskable.

When a second prefix byte directly follows a first one, the core marks it with a position flag, and that byte does not count. A load instruction can overwrite the whole register, top bit included, through a parallel load port.

The outputs are registered. Every strobe that arrives in a cycle shows up on the output one clock later.

Top module: `refresh_counter`

## Requirements
- R1: The low seven bits count upward and wrap from 0x7F to 0x00; counting never carries into bit 7.
- R2: Bit 7 keeps its value across every increment and changes only through a parallel load or a reset.
- R3: An opcode fetch strobe (`fetchStb`) increments the low seven bits by one on the next clock edge.
- R4: A halt cycle strobe (`haltStb`) increments the low seven bits by one, once for each cycle it is high.
- R5: A prefix strobe (`prefixStb`) increments the counter only when `prefixSecond` is 0. With `prefixSecond` at 1, marking the second byte of a double prefix, the value stays unchanged.
- R6: A non-maskable interrupt acceptance strobe (`nmiAckStb`) or a maskable interrupt acceptance strobe (`irqAckStb`) increments the counter once.
- R7: An active-low reset (`rstN` = 0) clears all 8 bits to 0x00.
- R8: When `loadEn` is 1, the next edge writes all 8 bits of `loadData`, bit 7 included. This takes priority over any increment strobe in the same cycle.
- R9: Several increment strobes high in the same cycle cause exactly one increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchStb | input | 1 | Opcode fetch event, one cycle |
| haltStb | input | 1 | Halted cycle event |
| prefixStb | input | 1 | Prefix byte fetched |
| prefixSecond | input | 1 | 1 when the current prefix is the second of a pair |
| nmiAckStb | input | 1 | Non-maskable interrupt accepted |
| irqAckStb | input | 1 | Maskable interrupt accepted |
| loadEn | input | 1 | Parallel load request |
| loadData | input | 8 | Value for a parallel load |
| refreshVal | output | 8 | Current register value |

## Verification
The bench starts with bit 7 set and the low bits at 0x7F, then fires an increment. A design that carried into bit 7 would show 0x00 instead of 0x80, and one that failed to wrap would show 0xFF or more.

The bench issues a second-position prefix on its own. A design that ignored the position flag would advance the counter when it should hold.

The bench raises a load together with a fetch in the same cycle. A design with the wrong priority would show the loaded value plus one.

The bench raises several strobes at once. A design that summed the events would step by two or more.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef struct packed {
    logic load;
    logic bump;
  } refreshCtrl_t;
endpackage

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int NUM_EVENTS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EVENTS-1:0] eventVec,
  input  logic                  loadEn,
  output refreshCtrl_t          ctrl
);
  logic [NUM_EVENTS-1:0] evMask;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EVENTS; gi++) begin : g_ev
      assign evMask[gi] = eventVec[gi];
    end
  endgenerate

  always_comb begin
    ctrl.load = loadEn;
    ctrl.bump = (|evMask) && !loadEn;
  end

  // R8: a load always wins over a bump
  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |-> !ctrl.bump);
  // R9: any number of events yields a single bump
  assert_single_bump_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(eventVec) > 1 && !loadEn) |-> ctrl.bump);
endmodule

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import refresh_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  refreshCtrl_t     ctrl,
  input  logic [REG_W-1:0] loadData,
  output logic [REG_W-1:0] value
);
  localparam int CNT_W = REG_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] lowQ;
  logic             topQ;
  logic [CNT_W-1:0] lowNext;

  assign lowNext = lowQ + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowQ <= '0;
      topQ <= 1'b0;
    end else if (ctrl.load) begin
      lowQ <= loadData[CNT_W-1:0];
      topQ <= loadData[REG_W-1];
    end else if (ctrl.bump) begin
      lowQ <= lowNext;
    end
  end

  assign value = {topQ, lowQ};

  // R1: the counter wraps at the top of its range
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.bump && !ctrl.load && lowQ == CNT_MAX) |=> lowQ == '0);
  // R2: the top bit holds when no load occurs
  assert_top_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(topQ));
  // R8: the loaded value appears in full
  assert_load_value_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> value == $past(loadData));
endmodule

// File: rtl/refresh_counter.sv
module refresh_counter
  import refresh_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchStb,
  input  logic             haltStb,
  input  logic             prefixStb,
  input  logic             prefixSecond,
  input  logic             nmiAckStb,
  input  logic             irqAckStb,
  input  logic             loadEn,
  input  logic [REG_W-1:0] loadData,
  output logic [REG_W-1:0] refreshVal
);
  localparam int NUM_EVENTS = 5;
  localparam int CNT_W = REG_W - 1;

  logic [NUM_EVENTS-1:0] eventVec;
  refreshCtrl_t          ctrl;

  assign eventVec = {irqAckStb, nmiAckStb, prefixStb && !prefixSecond, haltStb, fetchStb};

  refresh_ctrl #(.NUM_EVENTS(NUM_EVENTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .eventVec(eventVec), .loadEn(loadEn), .ctrl(ctrl)
  );

  refresh_datapath #(.REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .loadData(loadData), .value(refreshVal)
  );

  // R3: fetch advances the low bits by one
  assert_fetch_inc_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fetchStb && !loadEn) |=> refreshVal[CNT_W-1:0] == CNT_W'($past(refreshVal[CNT_W-1:0]) + 1));
  // R4: halt cycle advances the low bits by one
  assert_halt_inc_R4: assert property (@(posedge clk) disable iff (!rstN)
    (haltStb && !loadEn) |=> refreshVal[CNT_W-1:0] == CNT_W'($past(refreshVal[CNT_W-1:0]) + 1));
  // R5: a lone second prefix leaves the value unchanged
  assert_second_prefix_R5: assert property (@(posedge clk) disable iff (!rstN)
    (prefixStb && prefixSecond && !fetchStb && !haltStb && !nmiAckStb && !irqAckStb && !loadEn)
    |=> $stable(refreshVal));
  // R6: interrupt acceptance advances the low bits by one
  assert_intack_inc_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((nmiAckStb || irqAckStb) && !loadEn) |=> refreshVal[CNT_W-1:0] == CNT_W'($past(refreshVal[CNT_W-1:0]) + 1));
  // R7: reset clears the register
  assert_reset_clear_R7: assert property (@(posedge clk)
    !rstN |=> refreshVal == '0);
endmodule

// File: tb/sim_refresh_counter.sv
module sim_refresh_counter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchStb = 0, haltStb = 0, prefixStb = 0, prefixSecond = 0;
  logic nmiAckStb = 0, irqAckStb = 0, loadEn = 0;
  logic [7:0] loadData = 8'h00;
  logic [7:0] refreshVal;
  int errors = 0;
  int checks = 0;
  int model = 0;

  always #5 clk = ~clk;

  refresh_counter u0 (
    .clk(clk), .rstN(rstN), .fetchStb(fetchStb), .haltStb(haltStb),
    .prefixStb(prefixStb), .prefixSecond(prefixSecond), .nmiAckStb(nmiAckStb),
    .irqAckStb(irqAckStb), .loadEn(loadEn), .loadData(loadData), .refreshVal(refreshVal)
  );

  task automatic check(input string tag);
    checks++;
    if (refreshVal !== model[7:0]) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, refreshVal, model[7:0]);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic f, h, p, ps, n, i, ld, input logic [7:0] d, input string tag);
    fetchStb = f; haltStb = h; prefixStb = p; prefixSecond = ps;
    nmiAckStb = n; irqAckStb = i; loadEn = ld; loadData = d;
    @(posedge clk);
    if (!rstN) model = 0;
    else if (ld) model = d;
    else if (f || h || (p && !ps) || n || i)
      model = (model & 8'h80) | ((model + 1) & 8'h7F);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 0;
    step(0,0,0,0,0,0,1,8'hA5,"R7");   // load during reset is ignored
    rstN = 1;
    step(0,0,0,0,0,0,0,8'h00,"R7");
    for (int k = 0; k < 3; k++) step(1,0,0,0,0,0,0,8'h00,"R3");
    for (int k = 0; k < 4; k++) step(0,1,0,0,0,0,0,8'h00,"R4");
    step(0,0,1,0,0,0,0,8'h00,"R5");
    step(0,0,1,1,0,0,0,8'h00,"R5");
    step(0,0,0,0,1,0,0,8'h00,"R6");
    step(0,0,0,0,0,1,0,8'h00,"R6");
    step(0,0,0,0,0,0,1,8'hFF,"R8");
    step(1,0,0,0,0,0,0,8'h00,"R1");   // 0xFF -> 0x80
    step(0,1,0,0,0,0,0,8'h00,"R2");
    step(0,0,0,0,0,0,1,8'h7F,"R8");
    step(0,0,0,0,1,0,0,8'h00,"R1");   // 0x7F -> 0x00, bit 7 stays 0
    step(1,0,0,0,0,0,1,8'h3C,"R8");   // load beats fetch
    step(1,1,1,0,1,1,0,8'h00,"R9");
    step(1,0,1,1,0,0,0,8'h00,"R9");
    for (int k = 0; k < 130; k++) step(0,1,0,0,0,0,0,8'h00,"R4");
    step(0,0,0,0,0,0,1,8'h80,"R8");
    for (int k = 0; k < 128; k++) step(1,0,0,0,0,0,0,8'h00,"R2");
    rstN = 0;
    step(1,0,0,0,0,0,0,8'h00,"R7");
    rstN = 1;
    step(0,0,0,0,0,0,0,8'h00,"R7");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule